// File: doc/BRIEF.md
# TDM Timeslot Interchange Switch Core

The core moves 8-bit samples between timeslots of one time-division multiplexed stream. One input byte arrives per clock, one timeslot per byte. A strobe marks timeslot 0 of every frame, and a frame holds `NCH` timeslots. Every input byte is stored in one of three rotating frame banks.

Each output timeslot has its own connection word. That word chooses what the slot carries: a fixed byte supplied by the processor, the sample of a chosen input timeslot taken at the smallest possible latency, or that sample delayed so that every channel of a frame leaves together two frames later. Any other selector value parks the slot at an idle byte with its enable low.

The connection words are written through a simple write-only port. A written word applies from the next clock onward, so channels can be remapped while traffic runs.

Top module: `tsi_switch_core`

## Requirements
- R1: After reset, and until the first `frame_start`, `out_en` is 0 and `out_data` is 0xFF.
- R2: Bits 31:29 of a connection word hold the function code. The code 010 selects message mode, 011 selects fast mode and 100 selects aligned mode. Any other code makes that output slot carry 0xFF with `out_en` low.
- R3: In message mode, output slot m carries bits 7:0 of connection word m, with `out_en` high.
- R4: In fast mode, the source is input slot n. If n < m, output slot m of frame f carries input slot n of frame f. If n >= m, it carries input slot n of frame f-1.
- R5: In aligned mode, output slot m of frame f carries input slot n of frame f-2. The delay is therefore 2 frames + (m - n) slots. The shortest delay is 1 frame + 1 slot (n = NCH-1, m = 0). The longest is 3 frames - 1 slot (n = 0, m = NCH-1).
- R6: `frame_start` marks input slot 0, and the slot number then advances by one per clock, wrapping after NCH-1. Output slot m is presented on the clock after input slot m.
- R7: The source slot number n of a connection word sits in bits [8+CHW-1:8], where CHW = clog2(NCH).
- R8: A connection word written with `cm_wr` at address a governs output slot a from the next clock on. A write during running traffic changes only the addressed slot.
- R9: Frame banks are cleared at reset, so aligned or fast reads of frames that were never received return 0x00 with `out_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timeslot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | High in the cycle that carries input slot 0 |
| in_data | input | DATA_W | Input sample of the current slot |
| cm_wr | input | 1 | Connection word write strobe |
| cm_addr | input | CHW | Output slot whose word is written |
| cm_wdata | input | 32 | Connection word: code 31:29, source from bit 8, message 7:0 |
| out_data | output | DATA_W | Output sample, one cycle after its input slot |
| out_en | output | 1 | High when the output slot carries a valid byte |

## Verification
The bench builds the core with NCH = 8. With this value a frame lasts eight cycles, so several whole frames of bank rotation, including the first two frames read from cleared banks, fit in a short run. The small frame also brings both aligned-mode extremes within reach: last slot to first slot and first slot to last slot. Fast-mode sources before, equal to and after their output slot are covered, as are mid-frame rewrites whose effect lands exactly one slot later.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef logic [1:0] bank_t;

  localparam int CM_W    = 32;
  localparam int FN_LSB  = 29;
  localparam int SRC_LSB = 8;

  localparam logic [2:0] FN_MSG   = 3'b010;
  localparam logic [2:0] FN_FAST  = 3'b011;
  localparam logic [2:0] FN_ALIGN = 3'b100;

  // Next bank in rotation 0 -> 1 -> 2 -> 0
  function automatic bank_t bank_next(bank_t b);
    return (b == 2'd2) ? 2'd0 : bank_t'(b + 2'd1);
  endfunction

  // Bank written k frames before bank b (k = 1 or 2)
  function automatic bank_t bank_back(bank_t b, int k);
    return (k == 2) ? bank_next(b) : bank_next(bank_next(b));
  endfunction

  function automatic logic fn_switched(logic [2:0] fn);
    return (fn == FN_FAST) || (fn == FN_ALIGN);
  endfunction

  // Read bank for a switched slot
  function automatic bank_t pick_bank(bank_t wr, logic [2:0] fn, logic src_earlier);
    if (fn == FN_ALIGN) return bank_back(wr, 2);
    return src_earlier ? wr : bank_back(wr, 1);
  endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
  import tsi_pkg::*;
#(
  parameter int NCH = 32,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  output logic           running,
  output logic [CHW-1:0] slot,
  output bank_t          wr_bank
);
  localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

  logic           run_q;
  logic [CHW-1:0] slot_q;
  bank_t          bank_q;

  assign running = run_q | frame_start;

  always_comb begin
    if (frame_start)      slot = '0;
    else if (!run_q)      slot = '0;
    else if (slot_q == LAST) slot = '0;
    else                  slot = slot_q + 1'b1;
  end

  assign wr_bank = frame_start ? bank_next(bank_q) : bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      bank_q <= '0;
    end else begin
      run_q  <= running;
      slot_q <= slot;
      bank_q <= wr_bank;
    end
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int DATA_W = 8,
  localparam int CHW   = $clog2(NCH),
  localparam int NBANK = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  bank_t             wbank,
  input  logic [CHW-1:0]    waddr,
  input  logic [DATA_W-1:0] wdata,
  input  bank_t             rbank,
  input  logic [CHW-1:0]    raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] bank_rd [NBANK];
  logic              raddr_ok;

  assign raddr_ok = (32'(raddr) < NCH);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DATA_W-1:0] cells [NCH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < NCH; i++) cells[i] <= '0;
      end else if (we && (wbank == bank_t'(b))) begin
        cells[waddr] <= wdata;
      end
    end

    assign bank_rd[b] = raddr_ok ? cells[raddr] : '0;
  end

  always_comb begin
    case (rbank)
      2'd0:    rdata = bank_rd[0];
      2'd1:    rdata = bank_rd[1];
      default: rdata = bank_rd[2];
    endcase
  end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int DATA_W = 8,
  localparam int CHW   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cm_wr,
  input  logic [CHW-1:0]    cm_addr,
  input  logic [CM_W-1:0]   cm_wdata,
  input  logic [CHW-1:0]    rd_slot,
  output logic [2:0]        rd_fn,
  output logic [CHW-1:0]    rd_src,
  output logic [DATA_W-1:0] rd_msg
);
  logic [2:0]        fn_q  [NCH];
  logic [CHW-1:0]    src_q [NCH];
  logic [DATA_W-1:0] msg_q [NCH];
  logic              unused_bits;

  assign unused_bits = ^cm_wdata[FN_LSB-1:SRC_LSB+CHW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        fn_q[i]  <= '0;
        src_q[i] <= '0;
        msg_q[i] <= '0;
      end
    end else if (cm_wr && (32'(cm_addr) < NCH)) begin
      fn_q[cm_addr]  <= cm_wdata[FN_LSB +: 3];
      src_q[cm_addr] <= cm_wdata[SRC_LSB +: CHW];
      msg_q[cm_addr] <= cm_wdata[DATA_W-1:0];
    end
  end

  assign rd_fn  = fn_q[rd_slot];
  assign rd_src = src_q[rd_slot];
  assign rd_msg = msg_q[rd_slot];
endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core
  import tsi_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int DATA_W = 8,
  localparam int CHW   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cm_wr,
  input  logic [CHW-1:0]    cm_addr,
  input  logic [31:0]       cm_wdata,
  output logic [DATA_W-1:0] out_data,
  output logic              out_en
);
  logic              running;
  logic [CHW-1:0]    slot;
  bank_t             wr_bank;
  bank_t             rd_bank;
  logic [2:0]        cm_fn;
  logic [CHW-1:0]    cm_src;
  logic [DATA_W-1:0] cm_msg;
  logic [DATA_W-1:0] mem_rd;
  logic              src_earlier;
  logic [DATA_W-1:0] nxt_data;
  logic              nxt_en;

  tsi_frame_timer #(.NCH(NCH)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .running(running), .slot(slot), .wr_bank(wr_bank)
  );

  tsi_conn_mem #(.NCH(NCH), .DATA_W(DATA_W)) u_cmem (
    .clk(clk), .rst_n(rst_n), .cm_wr(cm_wr), .cm_addr(cm_addr),
    .cm_wdata(cm_wdata), .rd_slot(slot),
    .rd_fn(cm_fn), .rd_src(cm_src), .rd_msg(cm_msg)
  );

  assign src_earlier = (cm_src < slot);
  assign rd_bank     = pick_bank(wr_bank, cm_fn, src_earlier);

  tsi_data_mem #(.NCH(NCH), .DATA_W(DATA_W)) u_dmem (
    .clk(clk), .rst_n(rst_n), .we(running), .wbank(wr_bank),
    .waddr(slot), .wdata(in_data),
    .rbank(rd_bank), .raddr(cm_src), .rdata(mem_rd)
  );

  always_comb begin
    nxt_data = '1;
    nxt_en   = 1'b0;
    if (running) begin
      if (cm_fn == FN_MSG) begin
        nxt_data = cm_msg;
        nxt_en   = 1'b1;
      end else if (fn_switched(cm_fn)) begin
        nxt_data = mem_rd;
        nxt_en   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '1;
      out_en   <= 1'b0;
    end else begin
      out_data <= nxt_data;
      out_en   <= nxt_en;
    end
  end
endmodule

// File: rtl/tsi_switch_checker.sv
module tsi_switch_checker
  import tsi_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int DATA_W = 8,
  localparam int CHW   = $clog2(NCH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              running,
  input logic [CHW-1:0]    slot,
  input bank_t             wr_bank,
  input logic [2:0]        cm_fn,
  input logic [DATA_W-1:0] cm_msg,
  input logic [DATA_W-1:0] out_data,
  input logic              out_en
);
  localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

  p_idle_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> out_data == '1);

  p_quiet_before_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !out_en);

  p_bad_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cm_fn != FN_MSG && cm_fn != FN_FAST && cm_fn != FN_ALIGN) |=> !out_en);

  p_msg_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cm_fn == FN_MSG) |=> (out_en && out_data == $past(cm_msg)));

  p_switched_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (cm_fn == FN_FAST || cm_fn == FN_ALIGN)) |=> out_en);

  p_slot_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (frame_start || slot == (($past(slot) == LAST) ? '0 : $past(slot) + 1'b1)));

  p_bank_rotate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (frame_start ? (wr_bank != $past(wr_bank)) : (wr_bank == $past(wr_bank))));

  p_bank_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bank != 2'd3);
endmodule

bind tsi_switch_core tsi_switch_checker #(.NCH(NCH), .DATA_W(DATA_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .running(running),
  .slot(slot), .wr_bank(wr_bank), .cm_fn(cm_fn), .cm_msg(cm_msg),
  .out_data(out_data), .out_en(out_en)
);

// File: tb/tb_tsi_switch_core.sv
`timescale 1ns/1ps
module tb_tsi_switch_core;
  localparam int NCH = 8;
  localparam int CHW = $clog2(NCH);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           frame_start = 1'b0;
  logic [7:0]     in_data = '0;
  logic           cm_wr = 1'b0;
  logic [CHW-1:0] cm_addr = '0;
  logic [31:0]    cm_wdata = '0;
  logic [7:0]     out_data;
  logic           out_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tsi_switch_core #(.NCH(NCH), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_data(in_data),
    .cm_wr(cm_wr), .cm_addr(cm_addr), .cm_wdata(cm_wdata),
    .out_data(out_data), .out_en(out_en)
  );

  typedef struct {
    logic [7:0] d;
    logic       e;
    string      tag;
  } exp_t;
  exp_t q[$];

  // bench-side model state
  logic [2:0] s_fn  [NCH];
  int         s_src [NCH];
  logic [7:0] s_msg [NCH];
  bit  b_run   = 0;
  int  b_slot  = 0;
  int  b_frame = -1;
  bit  r8_mark = 0;

  function automatic logic [7:0] pat(int f, int c);
    if (f < 0) return 8'h00;
    return 8'((f * 59) ^ (c * 23) ^ 165);
  endfunction

  function automatic logic [31:0] word(logic [2:0] fn, int src, logic [7:0] msg);
    return {fn, 21'b0, msg} | (32'(src) << 8);
  endfunction

  task automatic check(string req, logic [7:0] d, logic e, logic [7:0] xd, logic xe);
    checks++;
    if (d !== xd || e !== xe) begin
      errors++;
      $display("FAIL %s: got data=%02h en=%0b, expected data=%02h en=%0b", req, d, e, xd, xe);
    end
  endtask

  task automatic step(bit fs, bit wr = 0, int a = 0, logic [31:0] w = '0);
    exp_t x;
    int   n;
    @(negedge clk);
    if (fs) begin
      b_run = 1; b_slot = 0; b_frame++;
    end else if (b_run) begin
      b_slot = (b_slot + 1) % NCH;
    end
    frame_start = fs;
    in_data     = b_run ? pat(b_frame, b_slot) : 8'h00;
    cm_wr       = wr;
    cm_addr     = CHW'(a);
    cm_wdata    = w;
    x.d = 8'hFF; x.e = 1'b0; x.tag = "R1";
    if (b_run) begin
      n = s_src[b_slot];
      case (s_fn[b_slot])
        3'b010: begin x.d = s_msg[b_slot]; x.e = 1'b1; x.tag = "R3"; end
        3'b011: begin
          x.d = (n < b_slot) ? pat(b_frame, n) : pat(b_frame - 1, n);
          x.e = 1'b1;
          x.tag = (b_frame < 1 && n >= b_slot) ? "R4/R9" : "R4/R6/R7";
        end
        3'b100: begin
          x.d = pat(b_frame - 2, n); x.e = 1'b1;
          x.tag = (b_frame < 2) ? "R5/R9" : "R5/R6/R7";
        end
        default: begin x.d = 8'hFF; x.e = 1'b0; x.tag = "R2"; end
      endcase
      if (r8_mark) x.tag = {x.tag, "/R8"};
    end
    q.push_back(x);
    if (wr) begin
      s_fn[a]  = w[31:29];
      s_src[a] = int'(w[8 +: CHW]);
      s_msg[a] = w[7:0];
    end
  endtask

  task automatic run_frame(int wslot = -1, int wa = 0, logic [31:0] ww = '0);
    for (int c = 0; c < NCH; c++) step(c == 0, c == wslot, wa, ww);
  endtask

  // monitor: compares each produced slot against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        check(x.tag, out_data, out_en, x.d, x.e);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no completion, expected end of stimulus");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      s_fn[i] = 3'b000; s_src[i] = 0; s_msg[i] = 8'h00;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check("R1", out_data, out_en, 8'hFF, 1'b0);   // reset state
    repeat (3) step(0);                           // R1: idle before first frame
    // program connections (R2, R3, R4, R5, R7)
    step(0, 1, 0, word(3'b100, 7, 8'h11));   // shortest aligned path
    step(0, 1, 7, word(3'b100, 0, 8'h22));   // longest aligned path
    step(0, 1, 1, word(3'b011, 3, 8'h33));   // fast, source after
    step(0, 1, 5, word(3'b011, 2, 8'h44));   // fast, source before
    step(0, 1, 3, word(3'b011, 3, 8'h55));   // fast, source equal
    step(0, 1, 2, word(3'b010, 6, 8'h5A));   // message
    step(0, 1, 4, word(3'b000, 1, 8'h66));   // idle code
    step(0, 1, 6, word(3'b111, 2, 8'h77));   // idle code
    repeat (5) run_frame();
    // R8: rewrites during traffic take effect one slot later
    r8_mark = 1;
    run_frame(3, 4, word(3'b010, 0, 8'hC3));
    run_frame(5, 6, word(3'b011, 7, 8'h00));
    run_frame(1, 2, word(3'b100, 4, 8'h00));
    r8_mark = 0;
    // R2: remaining undefined codes
    run_frame(7, 0, word(3'b001, 7, 8'h12));
    run_frame(6, 1, word(3'b101, 3, 8'h34));
    run_frame(2, 3, word(3'b110, 3, 8'h56));
    run_frame();
    repeat (2) step(0);
    repeat (2) @(posedge clk);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule